// File: doc/BRIEF.md
# GF(2^8) Column Mixing Unit

This unit applies the column-mixing step of a 128-bit block cipher round to one 32-bit state column (four bytes). A direction input selects the forward transform, used when encrypting, or the inverse transform, used when decrypting. The result is registered, so it appears one clock after the column is presented.

All finite-field products come from one building block, a multiply-by-{02} stage (xtime). Each input byte feeds a short chain of these stages that yields its doubled, quadrupled and octupled forms. Every coefficient in either matrix is then an XOR of chosen links from that chain. The unit has no general multiplier and no product table.

The unit works on one column at a time. The ordering of bytes across the whole state, and all key handling, belong to the surrounding datapath.

Top module: `gf_column_mixer`

## Requirements
- R1: With `inv` = 0, output byte i is {02}·a[i] ⊕ {03}·a[i+1] ⊕ a[i+2] ⊕ a[i+3] (indices mod 4). Byte 0 sits at `col_in[31:24]` and `col_out[31:24]`. Example: db 13 53 45 maps to 8e 4d a1 bc.
- R2: With `inv` = 1, output byte i is {0E}·a[i] ⊕ {0B}·a[i+1] ⊕ {0D}·a[i+2] ⊕ {09}·a[i+3]. Example: 8e 4d a1 bc maps to db 13 53 45.
- R3: Multiplication by {02} shifts the byte left by one bit and XORs 0x1B when the bit shifted out was 1. Example: column 80 00 00 00 mixes forward to 1b 80 80 9b.
- R4: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. This holds for back-to-back columns too.
- R5: A cycle with `in_valid` low leaves `col_out` unchanged, whatever `col_in` and `inv` carry.
- R6: While `rst_n` is low, `out_valid` and `col_out` are 0.
- R7: A column whose four bytes are equal passes through unchanged in both directions, and the all-zero column maps to zero.
- R8: Applying the inverse transform to the forward result returns the original column, for any column.
- R9: The direction is sampled in the same cycle as the column it applies to, so columns with alternating `inv` values each get their own transform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `col_in` and `inv` hold a column to process |
| inv | input | 1 | 0 = forward mix, 1 = inverse mix |
| col_in | input | 32 | Input column, byte 0 in the top bits |
| out_valid | output | 1 | `col_out` carries a new result |
| col_out | output | 32 | Registered mixed column, byte 0 in the top bits |

## Verification
On every cycle the assertions check the one-cycle valid timing, that the output holds while no column is accepted, and that uniform and zero columns map to themselves in either direction. Those are properties the checker can state without redoing the field arithmetic. The exact matrix products, the 0x1B reduction, direction switching between consecutive columns, and the round-trip identity on random columns can only be shown by the bench's scenarios. The bench compares them against known vectors and against a bit-serial multiply model.

// File: rtl/gf_mix_pkg.sv
package gf_mix_pkg;
   // number of bytes in one state column (matrix order)
   localparam int unsigned MIX_ROWS = 4;
   // default field width and reduction polynomial low bits
   localparam int unsigned MIX_BYTE_W = 8;
   localparam logic [7:0] MIX_POLY = 8'h1B;

   typedef enum logic {
      MIX_FWD = 1'b0,
      MIX_INV = 1'b1
   } mix_dir_e;
endpackage

// File: rtl/gf_xtime.sv
// Single multiply-by-x stage in GF(2^W), reduced by POLY.
module gf_xtime #(
   parameter int unsigned W    = 8,
   parameter logic [W-1:0] POLY = 8'h1B
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);
   logic carry;
   logic [W-1:0] shifted;

   always_comb begin
      carry   = a[W-1];
      shifted = {a[W-2:0], 1'b0};
      y       = carry ? (shifted ^ POLY) : shifted;
   end
endmodule

// File: rtl/gf_mul_chain.sv
// Successive doublings of one byte: stage[k] = x^k * a.
module gf_mul_chain #(
   parameter int unsigned W     = 8,
   parameter logic [W-1:0] POLY = 8'h1B,
   parameter int unsigned DEPTH = 3
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] x1,
   output logic [W-1:0] x2,
   output logic [W-1:0] x4,
   output logic [W-1:0] x8
);
   localparam int unsigned NSTG = DEPTH + 1;

   if (DEPTH < 3) begin : g_bad_depth
      $error("gf_mul_chain: DEPTH must be at least 3");
   end

   logic [W-1:0] stage [NSTG];

   assign stage[0] = a;

   for (genvar k = 1; k < NSTG; k++) begin : g_stage
      gf_xtime #(.W(W), .POLY(POLY)) u_xt (
         .a (stage[k-1]),
         .y (stage[k])
      );
   end

   assign x1 = stage[0];
   assign x2 = stage[1];
   assign x4 = stage[2];
   assign x8 = stage[3];

   if (NSTG > 4) begin : g_extra
      logic [W-1:0] spare_tap;
      assign spare_tap = stage[NSTG-1];
   end
endmodule

// File: rtl/gf_row_sum.sv
// Combines the doubling chains of the four (rotated) column bytes into one
// output byte. Forward row {02,03,01,01}, inverse row {0E,0B,0D,09}.
module gf_row_sum #(
   parameter int unsigned W = 8
) (
   input  logic         inv,
   // byte at rotation 0
   input  logic [W-1:0] r0_x2,
   input  logic [W-1:0] r0_x4,
   input  logic [W-1:0] r0_x8,
   // byte at rotation 1
   input  logic [W-1:0] r1_x1,
   input  logic [W-1:0] r1_x2,
   input  logic [W-1:0] r1_x8,
   // byte at rotation 2
   input  logic [W-1:0] r2_x1,
   input  logic [W-1:0] r2_x4,
   input  logic [W-1:0] r2_x8,
   // byte at rotation 3
   input  logic [W-1:0] r3_x1,
   input  logic [W-1:0] r3_x8,
   output logic [W-1:0] y
);
   logic [W-1:0] fwd_t0, fwd_t1, fwd_sum;
   logic [W-1:0] inv_t0, inv_t1, inv_t2, inv_t3, inv_sum;

   always_comb begin
      // forward: {02}a0, {03}a1 = x2 ^ x1, a2, a3
      fwd_t0  = r0_x2;
      fwd_t1  = r1_x2 ^ r1_x1;
      fwd_sum = fwd_t0 ^ fwd_t1 ^ r2_x1 ^ r3_x1;

      // inverse: {0E}=x8^x4^x2, {0B}=x8^x2^x1, {0D}=x8^x4^x1, {09}=x8^x1
      inv_t0  = r0_x8 ^ r0_x4 ^ r0_x2;
      inv_t1  = r1_x8 ^ r1_x2 ^ r1_x1;
      inv_t2  = r2_x8 ^ r2_x4 ^ r2_x1;
      inv_t3  = r3_x8 ^ r3_x1;
      inv_sum = inv_t0 ^ inv_t1 ^ inv_t2 ^ inv_t3;

      y = inv ? inv_sum : fwd_sum;
   end
endmodule

// File: rtl/gf_column_mixer.sv
// Registered forward/inverse column mix for one four-byte column.
module gf_column_mixer
   import gf_mix_pkg::*;
#(
   parameter int unsigned W     = MIX_BYTE_W,
   parameter logic [W-1:0] POLY = MIX_POLY[W-1:0],
   parameter int unsigned N     = MIX_ROWS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             inv,
   input  logic [N*W-1:0]   col_in,
   output logic             out_valid,
   output logic [N*W-1:0]   col_out
);
   localparam int unsigned COL_W = N * W;
   localparam int unsigned CHAIN = 3;

   // elaboration-time parameter checks
   if (N != 4) begin : g_bad_n
      $error("gf_column_mixer: the mixing matrix is 4x4, N must be 4");
   end
   if (W < 4) begin : g_bad_w
      $error("gf_column_mixer: W must be at least 4 for coefficient 0E");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("gf_column_mixer: reduction polynomial needs a constant term");
   end

   logic [W-1:0] a_byte [N];
   logic [W-1:0] m1 [N];
   logic [W-1:0] m2 [N];
   logic [W-1:0] m4 [N];
   logic [W-1:0] m8 [N];
   logic [W-1:0] y_byte [N];
   logic [COL_W-1:0] mixed;
   mix_dir_e dir;

   assign dir = mix_dir_e'(inv);

   // byte 0 in the top bits
   for (genvar i = 0; i < N; i++) begin : g_split
      assign a_byte[i] = col_in[COL_W-1-i*W -: W];
   end

   for (genvar i = 0; i < N; i++) begin : g_chain
      gf_mul_chain #(.W(W), .POLY(POLY), .DEPTH(CHAIN)) u_chain (
         .a  (a_byte[i]),
         .x1 (m1[i]),
         .x2 (m2[i]),
         .x4 (m4[i]),
         .x8 (m8[i])
      );
   end

   for (genvar i = 0; i < N; i++) begin : g_row
      localparam int unsigned J0 = i;
      localparam int unsigned J1 = (i + 1) % N;
      localparam int unsigned J2 = (i + 2) % N;
      localparam int unsigned J3 = (i + 3) % N;

      gf_row_sum #(.W(W)) u_row (
         .inv   (dir == MIX_INV),
         .r0_x2 (m2[J0]),
         .r0_x4 (m4[J0]),
         .r0_x8 (m8[J0]),
         .r1_x1 (m1[J1]),
         .r1_x2 (m2[J1]),
         .r1_x8 (m8[J1]),
         .r2_x1 (m1[J2]),
         .r2_x4 (m4[J2]),
         .r2_x8 (m8[J2]),
         .r3_x1 (m1[J3]),
         .r3_x8 (m8[J3]),
         .y     (y_byte[i])
      );

      assign mixed[COL_W-1-i*W -: W] = y_byte[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         col_out   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            col_out <= mixed;
         end
      end
   end
endmodule

// File: rtl/gf_column_mixer_chk.sv
module gf_column_mixer_chk #(
   parameter int unsigned W = 8,
   parameter int unsigned N = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           inv,
   input logic [N*W-1:0] col_in,
   input logic           out_valid,
   input logic [N*W-1:0] col_out
);
   logic uniform_in;
   logic zero_in;

   assign uniform_in = (col_in == {N{col_in[W-1:0]}});
   assign zero_in    = (col_in == '0);

   // R4
   valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R4
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(col_out));

   // R7
   uniform_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && uniform_in) |=> (col_out == $past(col_in)));

   // R7
   zero_maps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && zero_in) |=> (col_out == '0));

   // R9: the direction bit is a real input, must never be unknown when used
   dir_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !$isunknown(inv));
endmodule

bind gf_column_mixer gf_column_mixer_chk #(.W(W), .N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .inv       (inv),
   .col_in    (col_in),
   .out_valid (out_valid),
   .col_out   (col_out)
);

// File: tb/gf_column_mixer_bench.sv
module gf_column_mixer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        inv = 1'b0;
   logic [31:0] col_in = '0;
   logic        out_valid;
   logic [31:0] col_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gf_column_mixer u_gf_column_mixer (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .inv       (inv),
      .col_in    (col_in),
      .out_valid (out_valid),
      .col_out   (col_out)
   );

   // {dir, input column, expected column}
   localparam int NVEC = 10;
   localparam logic [64:0] VEC [NVEC] = '{
      {1'b0, 32'hdb135345, 32'h8e4da1bc},
      {1'b0, 32'hf20a225c, 32'h9fdc589d},
      {1'b0, 32'h2d26314c, 32'h4d7ebdf8},
      {1'b0, 32'hd4d4d4d5, 32'hd5d5d7d6},
      {1'b0, 32'h80000000, 32'h1b80809b},
      {1'b1, 32'h8e4da1bc, 32'hdb135345},
      {1'b1, 32'h9fdc589d, 32'hf20a225c},
      {1'b1, 32'h4d7ebdf8, 32'h2d26314c},
      {1'b1, 32'hd5d5d7d6, 32'hd4d4d4d5},
      {1'b1, 32'hc6c6c6c6, 32'hc6c6c6c6}
   };

   // bit-serial reference multiply, independent of the xtime chain
   function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p ^= (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p ^= (16'h011B << (i - 8));
      return p[7:0];
   endfunction

   function automatic logic [31:0] mix_model(input logic d, input logic [31:0] c);
      logic [7:0] cf [4];
      logic [7:0] a [4];
      logic [31:0] r = '0;
      if (d) begin cf[0]=8'h0e; cf[1]=8'h0b; cf[2]=8'h0d; cf[3]=8'h09; end
      else   begin cf[0]=8'h02; cf[1]=8'h03; cf[2]=8'h01; cf[3]=8'h01; end
      for (int i = 0; i < 4; i++) a[i] = c[31-8*i -: 8];
      for (int i = 0; i < 4; i++) begin
         logic [7:0] s = '0;
         for (int j = 0; j < 4; j++) s ^= gmul(a[(i+j)%4], cf[j]);
         r[31-8*i -: 8] = s;
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // present one column, return the registered result one clock later
   task automatic mix_one(input logic d, input logic [31:0] c, output logic [31:0] r);
      @(negedge clk);
      in_valid = 1'b1; inv = d; col_in = c;
      @(negedge clk);
      in_valid = 1'b0;
      r = col_out;
      check("R4 out_valid", {31'b0, out_valid}, 32'd1);
   endtask

   initial begin
      logic [31:0] res, fwd, held;
      // reset state with activity on the inputs
      repeat (2) @(negedge clk);
      in_valid = 1'b1; col_in = 32'hdeadbeef;
      @(negedge clk);
      check("R6 out_valid in reset", {31'b0, out_valid}, 32'd0);
      check("R6 col_out in reset", col_out, 32'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         mix_one(VEC[v][64], VEC[v][63:32], res);
         check(VEC[v][64] ? "R2 inverse vector" : "R1 forward vector", res, VEC[v][31:0]);
      end

      // R3 reduction: all-0x80 style bytes against the model
      mix_one(1'b0, 32'h80808080, res);
      check("R3 xtime reduction", res, mix_model(1'b0, 32'h80808080));
      mix_one(1'b1, 32'hff80017f, res);
      check("R3 reduction in inverse chain", res, mix_model(1'b1, 32'hff80017f));

      // R7 uniform and zero columns
      mix_one(1'b0, 32'h5a5a5a5a, res);
      check("R7 uniform forward", res, 32'h5a5a5a5a);
      mix_one(1'b1, 32'h00000000, res);
      check("R7 zero inverse", res, 32'h00000000);

      // R5 hold while idle with changing inputs
      held = col_out;
      @(negedge clk);
      col_in = 32'h12345678; inv = 1'b1;
      @(negedge clk);
      col_in = 32'hcafef00d; inv = 1'b0;
      @(negedge clk);
      check("R5 hold col_out", col_out, held);
      check("R4 out_valid idle", {31'b0, out_valid}, 32'd0);

      // R9 back-to-back columns with alternating direction
      @(negedge clk);
      in_valid = 1'b1; inv = 1'b0; col_in = 32'hdb135345;
      @(negedge clk);
      check("R9 stream fwd", col_out, 32'h8e4da1bc);
      inv = 1'b1; col_in = 32'h8e4da1bc;
      @(negedge clk);
      check("R9 stream inv", col_out, 32'hdb135345);
      check("R4 stream valid", {31'b0, out_valid}, 32'd1);
      inv = 1'b0; col_in = 32'h01010101;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 stream uniform", col_out, 32'h01010101);

      // R8 round trip on random columns, plus model comparison
      for (int k = 0; k < 24; k++) begin
         logic [31:0] c = $urandom;
         mix_one(1'b0, c, fwd);
         check("R1 random forward", fwd, mix_model(1'b0, c));
         mix_one(1'b1, fwd, res);
         check("R8 round trip", res, c);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule